// File: doc/BRIEF.md
# Constant-Label Symbol Permutation Node for Nonbinary Stochastic Decoding

This block sits on a single edge of the Tanner graph in a stochastic decoder for nonbinary LDPC codes over GF(2^p). Each edge carries two streams of field symbols, one per direction, and one symbol moves in each direction on every clock. The symbol travelling from the variable side toward the check side is multiplied by the edge label h = alpha^E. The symbol travelling from the check side back toward the variable side is multiplied by h^-1. With the label moved onto the edge, the check node reduces to a plain XOR of its inputs.

The label, the field width and the reducing polynomial are all parameters. Both multipliers are built at elaboration time from the label, so the block contains no general two-operand multiplier. A parameter chooses how each constant multiplier is built: as a table of 2^p entries, or as an XOR network whose columns are the images of the basis bits. A second parameter adds one output register per direction or leaves both paths combinational. Elaboration fails if the field width is out of range, if the polynomial's degree does not match the width, if the polynomial is not primitive, or if the label works out to zero.

Top module: `gf_perm_node`

## Requirements
- R1: The forward output is the forward input multiplied by alpha^EDGE_EXP in GF(2^SYM_W). Symbols are in polynomial basis, with bit k holding the coefficient of x^k, and arithmetic is reduced by POLY. The default is SYM_W=4 with POLY='h13, which is x^4+x+1.
- R2: The backward output is the backward input multiplied by alpha^-EDGE_EXP in the same field.
- R3: The zero symbol comes out as zero on both paths.
- R4: A nonzero input alpha^k comes out as alpha^((k+E) mod (2^p-1)) on the forward path and as alpha^((k-E) mod (2^p-1)) on the backward path. The nonzero symbols are therefore mapped one-to-one onto nonzero symbols.
- R5: Passing any symbol through the forward path and then through the backward path returns the original symbol.
- R6: With OUT_REG=1, the result for the inputs sampled at a rising edge appears on the outputs after that edge, and a new symbol is accepted on every cycle in each direction.
- R7: While rst_n is low, with OUT_REG=1, both outputs hold the zero symbol.
- R8: With OUT_REG=0, both outputs follow their inputs combinationally, in the same cycle.
- R9: An EDGE_EXP of 2^p-1 or more acts as EDGE_EXP mod (2^p-1).
- R10: MUL_IMPL=0 (table) and MUL_IMPL=1 (XOR network) give identical results for every symbol.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output registers |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| var_sym_i | input | SYM_W | Symbol arriving from the variable side |
| chk_sym_i | input | SYM_W | Symbol arriving from the check side |
| chk_sym_o | output | SYM_W | Symbol sent toward the check side, var_sym_i times h |
| var_sym_o | output | SYM_W | Symbol sent toward the variable side, chk_sym_i times h^-1 |

## Verification
The assertions assume that every input symbol is a valid field element of SYM_W bits and that the parameters pass the elaboration checks. No handshake is involved, since every cycle carries a symbol. The stimulus drives a fresh symbol on every cycle and holds it steady across the sampling edge. It first sweeps all 2^p values in each direction, including zero, and then mixes in pseudo-random symbols. A second instance uses the XOR-network variant, a combinational output and an exponent above the group order. That instance covers the round trip and the one-to-one mapping at the ports.

// File: rtl/gfpn_pkg.sv
package gfpn_pkg;

  // Widest field the helper functions support.
  localparam int GF_WMAX = 12;

  typedef logic [GF_WMAX-1:0] gf_word_t;

  // Multiply by alpha: shift left by one, reduce by the low part of the polynomial.
  function automatic gf_word_t gf_xtime(gf_word_t a, int w, gf_word_t poly_low);
    gf_word_t mask;
    gf_word_t res;
    logic     carry;
    mask  = gf_word_t'((1 << w) - 1);
    carry = a[w-1];
    res   = (a << 1) & mask;
    if (carry) res = res ^ poly_low;
    return res;
  endfunction

  // General shift-and-add product, used only at elaboration time.
  function automatic gf_word_t gf_mul(gf_word_t a, gf_word_t b, int w, gf_word_t poly_low);
    gf_word_t acc;
    gf_word_t run;
    acc = '0;
    run = a;
    for (int k = 0; k < GF_WMAX; k++) begin
      if (k < w && b[k]) acc = acc ^ run;
      run = gf_xtime(run, w, poly_low);
    end
    return acc;
  endfunction

  // alpha raised to a non-negative exponent.
  function automatic gf_word_t gf_alpha_pow(int e, int w, gf_word_t poly_low);
    gf_word_t r;
    r = gf_word_t'(1);
    for (int k = 0; k < e; k++) r = gf_xtime(r, w, poly_low);
    return r;
  endfunction

  // Multiplicative order of alpha, capped at 2^w.
  function automatic int gf_alpha_order(int w, gf_word_t poly_low);
    gf_word_t r;
    int       n;
    r = gf_xtime(gf_word_t'(1), w, poly_low);
    n = 1;
    while (r != gf_word_t'(1) && n < (1 << w)) begin
      r = gf_xtime(r, w, poly_low);
      n = n + 1;
    end
    return n;
  endfunction

  // Exponent of the inverse label, reduced into [0, 2^w-2].
  function automatic int gf_inv_exp(int e, int w);
    int q1;
    q1 = (1 << w) - 1;
    return (q1 - (e % q1)) % q1;
  endfunction

endpackage

// File: rtl/gfpn_const_mul.sv
module gfpn_const_mul #(
  parameter int                SYM_W    = 4,
  parameter gfpn_pkg::gf_word_t POLY_LOW = 'h3,
  parameter int                MUL_EXP  = 1,
  parameter int                MUL_IMPL = 0
) (
  input  logic [SYM_W-1:0] sym_in,
  output logic [SYM_W-1:0] sym_out
);
  import gfpn_pkg::*;

  localparam int       NUM_SYM = 1 << SYM_W;
  localparam gf_word_t H_VAL   = gf_alpha_pow(MUL_EXP, SYM_W, POLY_LOW);

  // Events brought out for the assertions below.
  logic sym_is_zero;
  logic prod_is_zero;

  generate
    if (MUL_IMPL == 0) begin : g_table
      logic [SYM_W-1:0] prod_lut [NUM_SYM];
      for (genvar g = 0; g < NUM_SYM; g++) begin : g_entry
        localparam gf_word_t ENTRY = gf_mul(gf_word_t'(g), H_VAL, SYM_W, POLY_LOW);
        assign prod_lut[g] = ENTRY[SYM_W-1:0];
      end
      assign sym_out = prod_lut[sym_in];
    end else begin : g_matrix
      logic [SYM_W-1:0] col_term [SYM_W];
      for (genvar k = 0; k < SYM_W; k++) begin : g_col
        localparam gf_word_t COL = gf_mul(gf_word_t'(1) << k, H_VAL, SYM_W, POLY_LOW);
        assign col_term[k] = sym_in[k] ? COL[SYM_W-1:0] : '0;
      end
      always_comb begin
        sym_out = '0;
        for (int k = 0; k < SYM_W; k++) sym_out = sym_out ^ col_term[k];
      end
    end
  endgenerate

  assign sym_is_zero  = (sym_in == '0);
  assign prod_is_zero = (sym_out == '0);

  always_comb begin
    if (sym_is_zero) begin
      AST_ZERO_STAYS_ZERO: assert (prod_is_zero); // R3
    end else begin
      AST_NONZERO_STAYS_NONZERO: assert (!prod_is_zero); // R4
    end
  end

endmodule

// File: rtl/gfpn_out_stage.sv
module gfpn_out_stage #(
  parameter int SYM_W   = 4,
  parameter int OUT_REG = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] d_in,
  output logic [SYM_W-1:0] q_out
);

  generate
    if (OUT_REG != 0) begin : g_reg
      logic [SYM_W-1:0] q_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= d_in;
      end
      assign q_out = q_r;

      AST_ONE_CYCLE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (q_r == $past(d_in))); // R6

      always @(posedge clk) begin
        if (!rst_n) begin
          AST_RESET_ZERO: assert (q_r == '0); // R7
        end
      end
    end else begin : g_wire
      assign q_out = d_in;
    end
  endgenerate

endmodule

// File: rtl/gf_perm_node.sv
module gf_perm_node #(
  parameter int SYM_W    = 4,
  parameter int POLY     = 'h13,
  parameter int EDGE_EXP = 7,
  parameter int OUT_REG  = 1,
  parameter int MUL_IMPL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] var_sym_i,
  input  logic [SYM_W-1:0] chk_sym_i,
  output logic [SYM_W-1:0] chk_sym_o,
  output logic [SYM_W-1:0] var_sym_o
);
  import gfpn_pkg::*;

  localparam int       GROUP_ORD = (1 << SYM_W) - 1;
  localparam gf_word_t POLY_LOW  = gf_word_t'(POLY) & gf_word_t'(GROUP_ORD);
  localparam int       EXP_FWD   = EDGE_EXP % GROUP_ORD;              // R9
  localparam int       EXP_BWD   = gf_inv_exp(EDGE_EXP, SYM_W);
  localparam gf_word_t H_FWD     = gf_alpha_pow(EXP_FWD, SYM_W, POLY_LOW);
  localparam gf_word_t H_BWD     = gf_alpha_pow(EXP_BWD, SYM_W, POLY_LOW);
  localparam int       ALPHA_ORD = gf_alpha_order(SYM_W, POLY_LOW);

  // Parameter screening at elaboration.
  generate
    if (SYM_W < 2 || SYM_W > GF_WMAX) begin : g_bad_width
      $error("gf_perm_node: SYM_W out of range");
    end
    if (((POLY >> SYM_W) != 1)) begin : g_bad_degree
      $error("gf_perm_node: POLY degree must equal SYM_W");
    end
    if (ALPHA_ORD != GROUP_ORD) begin : g_not_primitive
      $error("gf_perm_node: POLY is not primitive");
    end
    if (EDGE_EXP < 0 || H_FWD == '0) begin : g_zero_label
      $error("gf_perm_node: edge label must be a nonzero field element");
    end
  endgenerate

  // Products before the optional output stage, named for the assertions.
  logic [SYM_W-1:0] fwd_prod;
  logic [SYM_W-1:0] bwd_prod;

  gfpn_const_mul #(
    .SYM_W(SYM_W), .POLY_LOW(POLY_LOW), .MUL_EXP(EXP_FWD), .MUL_IMPL(MUL_IMPL)
  ) u_fwd_mul (
    .sym_in(var_sym_i), .sym_out(fwd_prod)
  );

  gfpn_const_mul #(
    .SYM_W(SYM_W), .POLY_LOW(POLY_LOW), .MUL_EXP(EXP_BWD), .MUL_IMPL(MUL_IMPL)
  ) u_bwd_mul (
    .sym_in(chk_sym_i), .sym_out(bwd_prod)
  );

  gfpn_out_stage #(.SYM_W(SYM_W), .OUT_REG(OUT_REG)) u_fwd_stage (
    .clk(clk), .rst_n(rst_n), .d_in(fwd_prod), .q_out(chk_sym_o)
  );

  gfpn_out_stage #(.SYM_W(SYM_W), .OUT_REG(OUT_REG)) u_bwd_stage (
    .clk(clk), .rst_n(rst_n), .d_in(bwd_prod), .q_out(var_sym_o)
  );

  // The two multipliers are built independently; h^-1 must undo h.
  logic [SYM_W-1:0] fwd_undone;
  gf_word_t         fwd_undone_w;
  assign fwd_undone_w = gf_mul(gf_word_t'(fwd_prod), H_BWD, SYM_W, POLY_LOW);
  assign fwd_undone   = fwd_undone_w[SYM_W-1:0];

  AST_ROUND_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_undone == var_sym_i); // R5

endmodule

// File: tb/sim_gf_perm_node.sv
module sim_gf_perm_node;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] a_var_i, a_chk_i, a_chk_o, a_var_o;
  logic [3:0] b_var_i, b_chk_i, b_chk_o, b_var_o;
  int         total = 0;
  int         bad   = 0;
  int         alog [15];
  int         lg   [16];
  logic [15:0] sb_q [$];
  bit          done = 1'b0;

  always #4 clk = ~clk;

  gf_perm_node #(.SYM_W(4), .POLY('h13), .EDGE_EXP(7), .OUT_REG(1), .MUL_IMPL(0)) u0 (
    .clk(clk), .rst_n(rst_n), .var_sym_i(a_var_i), .chk_sym_i(a_chk_i),
    .chk_sym_o(a_chk_o), .var_sym_o(a_var_o));

  // Variant: exponent 22 = 7 mod 15, combinational, XOR network.
  gf_perm_node #(.SYM_W(4), .POLY('h13), .EDGE_EXP(22), .OUT_REG(0), .MUL_IMPL(1)) u1 (
    .clk(clk), .rst_n(rst_n), .var_sym_i(b_var_i), .chk_sym_i(b_chk_i),
    .chk_sym_o(b_chk_o), .var_sym_o(b_var_o));

  // Power-form reference: x * alpha^e via log/antilog tables.
  function automatic logic [3:0] ref_mul(logic [3:0] x, int e);
    if (x == 4'd0) return 4'd0;
    return 4'(alog[(lg[x] + e) % 15]);
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [3:0] f, logic [3:0] b);
    @(negedge clk);
    a_var_i = f;
    a_chk_i = b;
    sb_q.push_back({ref_mul(f, 7), ref_mul(b, 8), f, b});
  endtask

  // Monitor: each registered result is visible just after the capturing edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        logic [15:0] it;
        it = sb_q.pop_front();
        chk((it[7:4] == 0) ? "R3 fwd zero" : "R1/R6 fwd", a_chk_o, it[15:12]);
        chk((it[3:0] == 0) ? "R3 bwd zero" : "R2/R6 bwd", a_var_o, it[11:8]);
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    logic [15:0] seen;
    v = 1;
    lg[0] = 0;
    for (int k = 0; k < 15; k++) begin
      alog[k] = v;
      lg[v]   = k;
      v = v << 1;
      if ((v & 16) != 0) v = v ^ 'h13;
    end

    rst_n = 1'b1;
    a_var_i = 4'h9; a_chk_i = 4'h5; b_var_i = 4'h0; b_chk_i = 4'h0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 reset fwd", a_chk_o, 4'h0);
    chk("R7 reset bwd", a_var_o, 4'h0);
    rst_n = 1'b1;

    // Exhaustive sweep, back to back, opposite orders in the two directions.
    for (int x = 0; x < 16; x++) drive(4'(x), 4'(15 - x));
    // Pseudo-random traffic.
    for (int n = 0; n < 40; n++) drive(4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)));
    drive(4'h0, 4'h0);
    repeat (3) @(negedge clk);

    // Variant instance: same cycle, reduced exponent, XOR-network build.
    for (int x = 0; x < 16; x++) begin
      b_var_i = 4'(x);
      b_chk_i = 4'(x);
      #1;
      chk("R8/R9/R10 fwd", b_chk_o, ref_mul(4'(x), 7));
      chk("R8/R9/R10 bwd", b_var_o, ref_mul(4'(x), 8));
    end

    // R5 round trip and R4 one-to-one mapping, observed at the ports.
    seen = '0;
    for (int x = 0; x < 16; x++) begin
      b_var_i = 4'(x);
      #1;
      if (x != 0) seen[b_chk_o] = 1'b1;
      b_chk_i = b_chk_o;
      #1;
      chk("R5 round trip", b_var_o, 4'(x));
    end
    total++;
    if (seen != 16'hFFFE) begin
      bad++;
      $display("FAIL R4 image act=%h exp=%h", seen, 16'hFFFE);
    end
    b_var_i = 4'h0;
    #1;
    chk("R3 zero variant", b_chk_o, 4'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule